// File: doc/BRIEF.md
# Radix-2 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles and returns the full signed product of `2*WIDTH` bits. A single-cycle strobe captures both operands. The block then retires one multiplier bit per cycle. In each step it recodes the multiplier bit it is examining, together with the bit examined in the step before, into an add, a subtract or a skip of the multiplicand. It then shifts its combined accumulator and multiplier register right by one place.

Negative operands need no pre-processing and the product needs no correction afterwards. The right shift keeps the sign, and the accumulator carries one guard bit above the operand width. The guard bit keeps intermediate sums exact even when the most negative operand is involved. A one-cycle completion flag marks the cycle in which the product is valid. The product then stays on the output until the next operation is loaded.

Top module: `booth_mul`

## Requirements
- R1: While reset (`rst_n` low, active low) is held and after it is released, `done` is 0 and `product` is all zeros until the first operation completes.
- R2: A `start` seen while the block is idle loads the operands. In the cycle after the loading edge, `product` reads the upper half as zero and the lower half equal to the loaded multiplier, and the previous-bit flop is 0.
- R3: Each step looks at the pair {current low bit of the multiplier field, previous bit}. Pair 2'b10 subtracts the multiplicand from the upper half, and the subtraction adds the bitwise inverse with a carry-in of 1. Pair 2'b01 adds the multiplicand. Pairs 2'b00 and 2'b11 leave the upper half unchanged.
- R4: After each add, subtract or skip, the whole register shifts right by one bit. The vacated top bit takes a copy of the sign, and the bit shifted out becomes the new previous bit.
- R5: Exactly `WIDTH` steps are performed. `done` is high in the cycle that follows the `WIDTH`-th step edge after the loading edge.
- R6: When `done` is high, `product` equals the signed product of the two loaded operands. For `WIDTH`=5, 5 times -3 gives a lower half of 5'b10001, with the full result -15.
- R7: The most negative operand times the most negative operand gives the exact positive result 2^(2*WIDTH-2).
- R8: A `start` that arrives while an operation is in progress is ignored. The running operation keeps its operands and its timing.
- R9: While the block is idle and `start` is low, `product` holds its value.
- R10: `done` is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load strobe; taken only when idle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| product | output | 2*WIDTH | Signed product register |
| done | output | 1 | One-cycle flag: product is valid |

## Verification
The bench builds the block with `WIDTH` set to 5. At that width, all 1024 operand pairs can be run in one pass. The sweep covers every recoding pattern, both signs, zero, and the most negative value times itself (-16 times -16 = 256). Directed runs at the same width cover the load state, a second start issued in the middle of an operation, the hold while idle, and the single-cycle completion flag.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } strobe_t;
endpackage

// File: rtl/booth_mul_ctrl.sv
module booth_mul_ctrl
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  output strobe_t strb,
  output logic    busy,
  output logic    done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] stepCnt;

  always_comb begin
    strb.load = start && !busy;
    strb.step = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else begin
      done <= 1'b0;
      if (strb.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (busy) begin
        if (stepCnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/booth_mul_dpath.sv
module booth_mul_dpath
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            strb,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product
);
  localparam int AW = WIDTH + 1;  // accumulator with one guard bit

  logic [AW-1:0]    accHi;
  logic [WIDTH-1:0] mulLo;
  logic             prevBit;
  logic [WIDTH-1:0] mcandReg;
  logic [AW-1:0]    mcandExt;
  logic [AW-1:0]    addend;
  logic [AW-1:0]    sum;
  logic             carryIn;
  logic [1:0]       pairBits;

  assign mcandExt = {mcandReg[WIDTH-1], mcandReg};
  assign pairBits = {mulLo[0], prevBit};

  always_comb begin
    unique case (pairBits)
      2'b10:   begin addend = ~mcandExt; carryIn = 1'b1; end
      2'b01:   begin addend = mcandExt;  carryIn = 1'b0; end
      default: begin addend = '0;        carryIn = 1'b0; end
    endcase
    sum = accHi + addend + {{(AW-1){1'b0}}, carryIn};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accHi    <= '0;
      mulLo    <= '0;
      prevBit  <= 1'b0;
      mcandReg <= '0;
    end else if (strb.load) begin
      accHi    <= '0;
      mulLo    <= mplier;
      prevBit  <= 1'b0;
      mcandReg <= mcand;
    end else if (strb.step) begin
      accHi   <= {sum[AW-1], sum[AW-1:1]};
      mulLo   <= {sum[0], mulLo[WIDTH-1:1]};
      prevBit <= mulLo[0];
    end
  end

  assign product = {accHi[WIDTH-1:0], mulLo};
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);
  strobe_t strb;
  logic    busy;

  booth_mul_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .strb(strb), .busy(busy), .done(done)
  );

  booth_mul_dpath #(.WIDTH(WIDTH)) uDpath (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .mcand(mcand), .mplier(mplier), .product(product)
  );
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [WIDTH-1:0]   mcand,
  input logic [WIDTH-1:0]   mplier,
  input logic [2*WIDTH-1:0] product,
  input logic               done,
  input logic               busy
);
  localparam int NW = $clog2(WIDTH + 2);

  logic [NW-1:0]      seenSteps;
  logic [2*WIDTH-1:0] expProd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seenSteps <= '0;
      expProd   <= '0;
    end else if (start && !busy) begin
      seenSteps <= '0;
      expProd   <= $signed({{WIDTH{mcand[WIDTH-1]}}, mcand}) *
                   $signed({{WIDTH{mplier[WIDTH-1]}}, mplier});
    end else if (busy) begin
      seenSteps <= seenSteps + 1'b1;
    end
  end

  AST_LOAD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (product == {{WIDTH{1'b0}}, $past(mplier)})); // R2
  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (seenSteps == NW'(WIDTH))); // R5
  AST_SIGNED_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == expProd)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

bind booth_mul booth_mul_chk #(.WIDTH(WIDTH)) uChk (
  .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
  .mplier(mplier), .product(product), .done(done), .busy(busy)
);

// File: tb/booth_mul_test.sv
module booth_mul_test;
  localparam int W = 5;
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic [2*W-1:0] product;
  logic           done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [2*W-1:0] expQ[$];
  int             startQ[$];
  string          tagQ[$];

  booth_mul #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mplier(mplier), .product(product), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] smul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] r;
    r = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    return r;
  endfunction

  // Monitor: pops the scoreboard whenever done is seen
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected done", product, '0);
      end else begin
        logic [2*W-1:0] e;
        int s;
        string t;
        e = expQ.pop_front();
        s = startQ.pop_front();
        t = tagQ.pop_front();
        check(product == e, t, product, e);
        check((cyc - s) == W + 1, "R5 latency", (2*W)'(cyc - s), (2*W)'(W + 1));
      end
    end
  end

  // Driver: loads one operation, optionally disturbs it, waits for completion
  task automatic runMul(input logic [W-1:0] a, input logic [W-1:0] b, input string tag,
                        input bit disturb);
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    expQ.push_back(smul(a, b));
    startQ.push_back(cyc);
    tagQ.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    check(product == {{W{1'b0}}, b}, "R2 load state", product, {{W{1'b0}}, b});
    if (disturb) begin
      @(negedge clk);
      start = 1'b1; mcand = ~a; mplier = ~b;  // R8: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishUp();
  end

  initial begin
    logic [2*W-1:0] held;
    repeat (3) @(negedge clk);
    check(product == '0 && done == 1'b0, "R1 in reset", product, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(product == '0 && done == 1'b0, "R1 after reset", product, '0);

    // R6 worked example: 5 x -3 = -15, low half 10001
    runMul(5'b00101, 5'b11101, "R6 five times minus three", 1'b0);
    check(product[W-1:0] == 5'b10001, "R6 low half", product, 10'(5'b10001));
    // R10 and R9: flag drops, value held while idle
    held = product;
    @(negedge clk);
    check(done == 1'b0, "R10 single cycle done", {9'b0, done}, '0);
    repeat (3) @(negedge clk);
    check(product == held, "R9 idle hold", product, held);

    // R7 most negative squared
    runMul(5'b10000, 5'b10000, "R7 most negative squared", 1'b0);
    check(product == 10'd256, "R7 value", product, 10'd256);
    // R3/R4: all-ones multiplier (one subtract then skips), alternating bits
    runMul(5'b01011, 5'b11111, "R3 run of ones", 1'b0);
    runMul(5'b10011, 5'b01010, "R4 alternating pairs", 1'b0);
    runMul(5'b01111, 5'b10000, "R4 sign shift", 1'b0);
    // R8 start during operation ignored
    runMul(5'b00111, 5'b11010, "R8 start while busy", 1'b1);

    // Exhaustive sweep: R3 R4 R6
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 32; j++) begin
        runMul(W'(i), W'(j), "R6 sweep", 1'b0);
      end
    end
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R5 all results seen", (2*W)'(expQ.size()), '0);
    finishUp();
  end
endmodule